// File: doc/BRIEF.md
# Control Endpoint Stage Sequencer

This block follows a device-side control transfer on endpoint 0 through its stages. Its inputs are single-cycle event strobes: a setup packet (carrying the transfer direction and the requested byte count), an IN packet handed to the link, an OUT packet received, a completion of the last IN packet, and a stall request. Its outputs are the current stage code, a stall-handshake enable, a one-cycle status-stage trigger, and the number of data bytes still outstanding.

The stage moves between waiting, IN data, OUT data, "last IN sent, awaiting completion" and stalled. A new setup packet always wins. It cancels whatever transfer is in progress, and it also clears a stall. The block also holds a six-byte reply buffer. Firmware fills this buffer for standard-request answers: two bytes for a status reply, six for the longest reply.

Top module: `ep0_stage_seq`

## Requirements
- R1: After reset the stage is 1 (waiting), the stall enable and the status trigger are 0, the outstanding count is 0, and every reply byte reads 0.
- R2: A setup packet with a nonzero length and the device-to-host direction (`setup_dir_in`=1) moves to stage 2 (IN data) and loads the outstanding count with the length.
- R3: A setup packet with a nonzero length and the host-to-device direction moves to stage 3 (OUT data) and loads the outstanding count with the length.
- R4: A setup packet with length 0 leaves the stage at 1 and raises the status trigger on the next cycle.
- R5: In stage 2 an IN packet reduces the count by its size, saturating at 0. The stage moves to 4 when the packet is shorter than MAX_PKT or covers the rest of the count. Otherwise it stays in 2.
- R6: In stage 4 a completion event returns to stage 1 and raises the status trigger.
- R7: In stage 3 an OUT packet reduces the count. A short packet, or one that reaches the requested length, returns to stage 1 and raises the status trigger.
- R8: A stall request without a setup packet moves to stage 5 from any stage, with the stall enable high. Data and completion events leave stage 5 and the count unchanged.
- R9: A setup packet in any stage, including stage 5 and including a cycle that also carries a stall request, is decoded as a new transfer by R2 to R4.
- R10: The status trigger is high for exactly the cycle after a zero-length setup, a completion in stage 4, or the end of an OUT data stage, and at no other time.
- R11: Reply byte writes to indices 0 to 5 are stored and read back at that index. Writes to indices 6 and 7 are dropped, and reads of those indices return 0.
- R12: Events that do not belong to the current stage change neither the stage nor the count. These are IN packets outside stage 2, OUT packets outside stage 3, and completions outside stage 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_valid | input | 1 | Setup packet received this cycle |
| setup_dir_in | input | 1 | 1: device-to-host data stage |
| setup_len | input | LEN_W | Requested data stage length in bytes |
| in_sent | input | 1 | IN data packet handed off |
| in_bytes | input | BW | Size of that IN packet |
| out_rcvd | input | 1 | OUT data packet received |
| out_bytes | input | BW | Size of that OUT packet |
| xfer_done | input | 1 | Completion of the last IN packet |
| stall_req | input | 1 | Request to stall the endpoint |
| rsp_we | input | 1 | Reply buffer write enable |
| rsp_widx | input | 3 | Reply buffer write index |
| rsp_wdata | input | 8 | Reply buffer write byte |
| rsp_ridx | input | 3 | Reply buffer read index |
| rsp_rdata | output | 8 | Reply buffer byte at rsp_ridx |
| stage | output | 3 | Current stage code, 1 to 5 |
| stall_hs | output | 1 | Answer with stall handshake |
| status_go | output | 1 | One-cycle status stage trigger |
| remain | output | LEN_W | Data bytes still outstanding |

## Verification
Every event lands on the next rising edge. The stage, count, stall enable and status trigger therefore change one cycle after the strobe, and a reply byte can be read back one cycle after its write. The bench drives each stimulus on a falling edge and advances its own model by one step. It then compares all outputs on the following falling edge, which is the first point at which the design's registers hold the result. The read data is combinational from stored bytes, so it is compared in that same sample against the model's buffer after its write.

// File: rtl/ep0_stage_seq.sv
module ep0_stage_seq #(
  parameter int MAX_PKT   = 64,
  parameter int LEN_W     = 16,
  parameter int RSP_BYTES = 6,
  localparam int BW = $clog2(MAX_PKT + 1),
  localparam int IW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_valid,
  input  logic             setup_dir_in,
  input  logic [LEN_W-1:0] setup_len,
  input  logic             in_sent,
  input  logic [BW-1:0]    in_bytes,
  input  logic             out_rcvd,
  input  logic [BW-1:0]    out_bytes,
  input  logic             xfer_done,
  input  logic             stall_req,
  input  logic             rsp_we,
  input  logic [IW-1:0]    rsp_widx,
  input  logic [7:0]       rsp_wdata,
  input  logic [IW-1:0]    rsp_ridx,
  output logic [7:0]       rsp_rdata,
  output logic [2:0]       stage,
  output logic             stall_hs,
  output logic             status_go,
  output logic [LEN_W-1:0] remain
);
  localparam logic [2:0] S_WAIT = 3'd1, S_IN = 3'd2, S_OUT = 3'd3, S_INEND = 3'd4, S_STALL = 3'd5;

  logic [2:0]       nstage;
  logic [LEN_W-1:0] nremain;
  logic             nstat;
  logic [7:0]       rsp_mem [RSP_BYTES];

  wire [LEN_W-1:0] in_ext  = LEN_W'(in_bytes);
  wire [LEN_W-1:0] out_ext = LEN_W'(out_bytes);
  wire in_short  = in_bytes  < BW'(MAX_PKT);
  wire out_short = out_bytes < BW'(MAX_PKT);

  always_comb begin
    nstage  = stage;
    nremain = remain;
    nstat   = 1'b0;
    if (setup_valid) begin
      nremain = setup_len;
      if (setup_len == '0) begin
        nstage = S_WAIT;
        nstat  = 1'b1;
      end else begin
        nstage = setup_dir_in ? S_IN : S_OUT;
      end
    end else if (stall_req) begin
      nstage = S_STALL;
    end else begin
      case (stage)
        S_IN: if (in_sent) begin
          nremain = (in_ext >= remain) ? '0 : remain - in_ext;
          if (in_short || in_ext >= remain) nstage = S_INEND;
        end
        S_INEND: if (xfer_done) begin
          nstage = S_WAIT;
          nstat  = 1'b1;
        end
        S_OUT: if (out_rcvd) begin
          nremain = (out_ext >= remain) ? '0 : remain - out_ext;
          if (out_short || out_ext >= remain) begin
            nstage = S_WAIT;
            nstat  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage     <= S_WAIT;
      remain    <= '0;
      status_go <= 1'b0;
    end else begin
      stage     <= nstage;
      remain    <= nremain;
      status_go <= nstat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RSP_BYTES; i++) rsp_mem[i] <= '0;
    end else if (rsp_we && 32'(rsp_widx) < RSP_BYTES) begin
      rsp_mem[rsp_widx] <= rsp_wdata;
    end
  end

  assign rsp_rdata = (32'(rsp_ridx) < RSP_BYTES) ? rsp_mem[rsp_ridx] : 8'h00;
  assign stall_hs  = (stage == S_STALL);

  a_r2_enter_in: assert property (@(posedge clk) disable iff (!rst_n)
    setup_valid && setup_dir_in && setup_len != '0 |=> stage == S_IN && remain == $past(setup_len));
  a_r4_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    setup_valid && setup_len == '0 |=> stage == S_WAIT && status_go);
  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req && !setup_valid |=> stall_hs && $stable(remain));
  a_r9_setup_clears: assert property (@(posedge clk) disable iff (!rst_n)
    setup_valid |=> !stall_hs);
  a_r10_status_wait: assert property (@(posedge clk) disable iff (!rst_n)
    status_go |-> stage == S_WAIT);
  a_r6_done: assert property (@(posedge clk) disable iff (!rst_n)
    stage == S_INEND && xfer_done && !setup_valid && !stall_req |=> stage == S_WAIT && status_go);
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stage == S_WAIT && !setup_valid && !stall_req |=> stage == S_WAIT && $stable(remain) && !status_go);
endmodule

// File: tb/tb_ep0_stage_seq.sv
module tb_ep0_stage_seq;
  localparam int MAXP = 64, LW = 16, BW = 7;
  logic clk = 0, rst_n = 0;
  logic setup_valid = 0, setup_dir_in = 0, in_sent = 0, out_rcvd = 0, xfer_done = 0, stall_req = 0, rsp_we = 0;
  logic [LW-1:0] setup_len = 0;
  logic [BW-1:0] in_bytes = 0, out_bytes = 0;
  logic [2:0] rsp_widx = 0, rsp_ridx = 0;
  logic [7:0] rsp_wdata = 0, rsp_rdata;
  logic [2:0] stage;
  logic stall_hs, status_go;
  logic [LW-1:0] remain;

  int checks = 0, failures = 0;
  int m_stage = 1, m_remain = 0, m_stat = 0;
  int m_rsp [6];

  always #2 clk = ~clk;

  ep0_stage_seq dut (.clk, .rst_n, .setup_valid, .setup_dir_in, .setup_len, .in_sent, .in_bytes,
    .out_rcvd, .out_bytes, .xfer_done, .stall_req, .rsp_we, .rsp_widx, .rsp_wdata, .rsp_ridx,
    .rsp_rdata, .stage, .stall_hs, .status_go, .remain);

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int sub_sat(int a, int b);
    return (b >= a) ? 0 : a - b;
  endfunction

  // advance the reference model by one cycle; returns the requirement exercised
  function automatic string model_step();
    string tag = "R12";
    m_stat = 0;
    if (rsp_we && rsp_widx < 6) m_rsp[rsp_widx] = rsp_wdata;
    if (setup_valid) begin
      tag = (m_stage == 5 || stall_req) ? "R9" : (setup_len == 0) ? "R4" : setup_dir_in ? "R2" : "R3";
      m_remain = setup_len;
      if (setup_len == 0) begin m_stage = 1; m_stat = 1; end
      else m_stage = setup_dir_in ? 2 : 3;
    end else if (stall_req) begin
      tag = "R8"; m_stage = 5;
    end else if (m_stage == 5) begin
      tag = "R8";
    end else if (m_stage == 2 && in_sent) begin
      tag = "R5";
      if (in_bytes < MAXP || in_bytes >= m_remain) m_stage = 4;
      m_remain = sub_sat(m_remain, in_bytes);
    end else if (m_stage == 4 && xfer_done) begin
      tag = "R6"; m_stage = 1; m_stat = 1;
    end else if (m_stage == 3 && out_rcvd) begin
      tag = "R7";
      if (out_bytes < MAXP || out_bytes >= m_remain) begin m_stage = 1; m_stat = 1; end
      m_remain = sub_sat(m_remain, out_bytes);
    end
    return tag;
  endfunction

  task automatic compare(string tag);
    chk(tag, "stage", stage, m_stage);
    chk(tag, "remain", remain, m_remain);
    chk(tag, "stall_hs", stall_hs, m_stage == 5);
    chk("R10", "status_go", status_go, m_stat);
    chk("R11", "rsp_rdata", rsp_rdata, rsp_ridx < 6 ? m_rsp[rsp_ridx] : 0);
  endtask

  task automatic step();
    string tag = model_step();
    @(negedge clk);
    compare(tag);
    {setup_valid, in_sent, out_rcvd, xfer_done, stall_req, rsp_we} = '0;
  endtask

  task automatic do_setup(bit din, int len);
    setup_valid = 1; setup_dir_in = din; setup_len = LW'(len); step();
  endtask

  initial begin
    #700us;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 6; i++) m_rsp[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "stage", stage, 1);
    chk("R1", "stall_hs", stall_hs, 0);
    chk("R1", "status_go", status_go, 0);
    chk("R1", "remain", remain, 0);
    for (int i = 0; i < 8; i++) begin
      rsp_ridx = 3'(i); #0.5;
      chk("R1", "rsp byte", rsp_rdata, 0);
    end

    // R4 zero-length setup, then pulse clears (R10)
    do_setup(1, 0);
    step();
    // R2/R5 exact multiple of MAX_PKT needs the count to finish
    do_setup(1, 128);
    in_sent = 1; in_bytes = 64; step();
    chk("R5", "still in data", stage, 2);
    xfer_done = 1; step();                     // R12 completion ignored in stage 2
    in_sent = 1; in_bytes = 64; step();
    chk("R5", "last IN", stage, 4);
    in_sent = 1; in_bytes = 10; step();        // R12 ignored in stage 4
    xfer_done = 1; step();
    chk("R6", "back to wait", stage, 1);
    // R3/R7 short OUT packet ends early
    do_setup(0, 200);
    out_rcvd = 1; out_bytes = 64; step();
    out_rcvd = 1; out_bytes = 5; step();
    chk("R7", "short ends", stage, 1);
    // R8 stall, events ignored, R9 setup clears
    do_setup(0, 40);
    stall_req = 1; step();
    out_rcvd = 1; out_bytes = 3; step();
    in_sent = 1; in_bytes = 3; step();
    chk("R8", "held", remain, 40);
    do_setup(1, 9);
    chk("R9", "setup clears stall", stage, 2);
    setup_valid = 1; setup_dir_in = 0; setup_len = 7; stall_req = 1; step();
    chk("R9", "setup beats stall", stage, 3);
    // R11 buffer writes, out-of-range dropped
    for (int i = 0; i < 8; i++) begin
      rsp_we = 1; rsp_widx = 3'(i); rsp_wdata = 8'(8'hA0 + i); rsp_ridx = 3'(i); step();
    end
    rsp_ridx = 5; #0.5; chk("R11", "byte5", rsp_rdata, 8'hA5);
    rsp_ridx = 6; #0.5; chk("R11", "byte6", rsp_rdata, 0);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(99);
      setup_valid  = (r < 8);
      setup_dir_in = $urandom_range(1);
      setup_len    = LW'(($urandom_range(3) == 0) ? 0 : $urandom_range(260));
      stall_req    = ($urandom_range(99) < 3);
      in_sent      = $urandom_range(1);
      in_bytes     = BW'(($urandom_range(1) == 0) ? MAXP : $urandom_range(MAXP));
      out_rcvd     = $urandom_range(1);
      out_bytes    = BW'(($urandom_range(1) == 0) ? MAXP : $urandom_range(MAXP));
      xfer_done    = ($urandom_range(3) == 0);
      rsp_we       = $urandom_range(1);
      rsp_widx     = 3'($urandom_range(7));
      rsp_wdata    = 8'($urandom_range(255));
      rsp_ridx     = 3'($urandom_range(7));
      step();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule